// File: doc/BRIEF.md
# Interrupt Distributor Control and Identification Registers

This block is the 32-bit register slice that sits at the start of an interrupt distributor's register space. It serves three words: a control word holding the global interrupt-forwarding enable, a read-only type word describing the distributor's size, and an identification word made of a product code, a revision field and an implementer code. Only offset bits [3:2] select a word; the fourth slot reads as zero.

Turning forwarding on, from off, produces a one-cycle wake pulse on one line per online processor, so that sleeping processors re-examine their pending interrupts. A separate host-side write port lets management software change the identification revision. The host port checks every request and answers it with a done pulse and an error flag. A revision of 2 or 3, written with every other identification bit unchanged, is stored and sets a sticky flag. Neighbouring register blocks use that flag to allow interrupt-group programming from the host. Revision 1 means interrupts are reported as group 0. Revision 2 or later means groups are programmable and are signalled according to the group they are given.

The host port runs a three-state sequence. `HS_IDLE` waits for a request, and a request taken there (transition *accept*) is captured and moves to `HS_EVAL`. In `HS_EVAL` the request is judged and committed (transition *judge*), moving to `HS_RESP`. `HS_RESP` raises the done pulse for one cycle and returns to `HS_IDLE` (transition *release*).

Top module: `dist_ctrl_regs`

## Requirements
- R1: After reset, forwarding is disabled, the revision equals parameter `REV_RESET`, the group-unlock flag is 0 and no wake line or host response is active.
- R2: A guest write with offset bits [3:2] = 0 and bits [1:0] = 0 sets the enable to data bit 0. A guest read of that word returns the enable in bit 0 and zeros in bits [31:1], with `g_rvalid` high in the cycle after `g_rd`.
- R3: A control write that moves the enable from 0 to 1 raises `wake_o[i]` for exactly one cycle, starting the cycle after the write, for every `i` below `online_cpus`. A write that leaves the enable at 1, or clears it, raises no wake line.
- R4: The type word (offset 0x4) reads bits [4:0] = `NUM_IRQ`/32 − 1, bits [7:5] = `online_cpus` − 1 and zeros above.
- R5: The identification word (offset 0x8) reads `PRODUCT_ID` in bits [31:24], the revision in bits [15:12], `IMPLEMENTER` in bits [11:0] and zeros in bits [23:16].
- R6: Guest writes to offsets 0x4, 0x8 and 0xC change nothing, and offset 0xC reads as zero.
- R7: A guest access with offset bits [1:0] not 0 changes nothing and reads zero, still with `g_rvalid` high one cycle after `g_rd`.
- R8: A host write to offset 0x8 whose data differs from the current identification word in any bit outside [15:12] is answered with an error and changes nothing.
- R9: A host write to offset 0x8 that differs only in bits [15:12] and carries revision 2 or 3 is stored and sets the group-unlock flag. The flag stays 1 until reset.
- R10: A host write to offset 0x8 carrying any revision other than 2 or 3 is answered with an error and changes nothing, even when the data equals the current word.
- R11: A host request taken at clock edge N raises `h_done` for exactly the one cycle after edge N+1. `h_err` is valid only with `h_done`. Requests presented while a request is in progress are ignored.
- R12: A host write to offset 0x0 sets the enable from data bit 0 without error, including the wake behaviour of R3. Host writes to 0x4 or 0xC change nothing without error, and a host write with offset bits [1:0] not 0 is answered with an error. A guest control write in the same cycle takes precedence over the host write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| online_cpus | input | CPU_W | Number of online processors, 1 to MAX_CPU |
| g_wr | input | 1 | Guest write strobe |
| g_rd | input | 1 | Guest read strobe |
| g_addr | input | 4 | Guest byte offset within the slice |
| g_wdata | input | 32 | Guest write data |
| g_rdata | output | 32 | Guest read data, valid with g_rvalid |
| g_rvalid | output | 1 | Read data valid, one cycle after g_rd |
| h_wr | input | 1 | Host write request, taken in HS_IDLE |
| h_addr | input | 4 | Host byte offset within the slice |
| h_wdata | input | 32 | Host write data |
| h_done | output | 1 | One-cycle response to a host request |
| h_err | output | 1 | Host request rejected, valid with h_done |
| fwd_enable | output | 1 | Global forwarding enable |
| group_unlock | output | 1 | Sticky flag permitting host group programming |
| wake_o | output | MAX_CPU | One-cycle wake pulse per online processor |

## Verification
The bench builds the block with `NUM_IRQ` = 256, `MAX_CPU` = 8 and `REV_RESET` = 1. The type field is therefore the non-trivial value 7, and every wake line and processor-count encoding from 1 to 8 can be reached by varying `online_cpus`. Starting at revision 1 with the flag clear means the unlock transition is observed. It also means a host write that merely repeats the current, legal-looking word is seen to be rejected. Random guest and host traffic, including misaligned offsets and identification writes with single-bit damage outside the revision field, is mixed with directed cases for the wake edge, the busy host port and guest priority.

// File: rtl/dist_regs_pkg.sv
package dist_regs_pkg;

    localparam int OFS_W    = 4;
    localparam int REV_LSB  = 12;
    localparam int REV_W    = 4;
    localparam int PROD_LSB = 24;
    localparam int PROD_W   = 8;
    localparam int IMPL_W   = 12;
    localparam logic [31:0] REV_MASK = 32'((1 << REV_W) - 1) << REV_LSB;

    typedef enum logic [1:0] {
        WORD_CTRL  = 2'd0,
        WORD_TYPE  = 2'd1,
        WORD_IDENT = 2'd2,
        WORD_RSVD  = 2'd3
    } word_e;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_EVAL = 2'd1,
        HS_RESP = 2'd2
    } host_state_e;

    function automatic word_e word_of(input logic [OFS_W-1:0] ofs);
        return word_e'(ofs[3:2]);
    endfunction

    function automatic logic is_aligned(input logic [OFS_W-1:0] ofs);
        return ofs[1:0] == 2'b00;
    endfunction

    function automatic logic rev_allowed(input logic [REV_W-1:0] rev);
        return (rev == REV_W'(2)) || (rev == REV_W'(3));
    endfunction

endpackage

// File: rtl/dist_type_word.sv
module dist_type_word
    import dist_regs_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int MAX_CPU = 8,
    localparam int CPU_W  = $clog2(MAX_CPU + 1)
) (
    input  logic [CPU_W-1:0] online_i,
    output logic [31:0]      word_o
);
    localparam logic [4:0] LINES_FIELD = 5'(NUM_IRQ / 32 - 1);

    logic [CPU_W-1:0] cpus_m1;
    logic             unused_cpu_hi;

    assign cpus_m1       = online_i - CPU_W'(1);
    assign unused_cpu_hi = cpus_m1[CPU_W-1];
    assign word_o        = {24'd0, cpus_m1[2:0], LINES_FIELD};
endmodule

// File: rtl/dist_ident_word.sv
module dist_ident_word
    import dist_regs_pkg::*;
#(
    parameter logic [PROD_W-1:0] PRODUCT_ID  = 8'h4B,
    parameter logic [IMPL_W-1:0] IMPLEMENTER = 12'h43B
) (
    input  logic [REV_W-1:0] rev_i,
    output logic [31:0]      word_o
);
    always_comb begin
        word_o = '0;
        word_o[PROD_LSB +: PROD_W] = PRODUCT_ID;
        word_o[REV_LSB +: REV_W]   = rev_i;
        word_o[0 +: IMPL_W]        = IMPLEMENTER;
    end
endmodule

// File: rtl/dist_host_fsm.sv
module dist_host_fsm
    import dist_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_wr,
    input  logic [OFS_W-1:0] h_addr,
    input  logic [31:0]      h_wdata,
    input  logic [31:0]      ident_i,
    output logic             h_done,
    output logic             h_err,
    output logic             rev_we,
    output logic [REV_W-1:0] rev_new,
    output logic             ctrl_we,
    output logic             ctrl_bit
);
    host_state_e      state_q, state_d;
    logic [OFS_W-1:0] cap_addr;
    logic [31:0]      cap_data;
    logic             err_q, reject;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (h_wr) state_d = HS_EVAL;   // accept
            HS_EVAL: state_d = HS_RESP;             // judge
            HS_RESP: state_d = HS_IDLE;             // release
            default: state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
            err_q    <= 1'b0;
        end else begin
            if (state_q == HS_IDLE && h_wr) begin
                cap_addr <= h_addr;
                cap_data <= h_wdata;
            end
            if (state_q == HS_EVAL) err_q <= reject;
        end
    end

    // outputs
    always_comb begin
        reject   = 1'b0;
        rev_we   = 1'b0;
        ctrl_we  = 1'b0;
        rev_new  = cap_data[REV_LSB +: REV_W];
        ctrl_bit = cap_data[0];
        h_done   = (state_q == HS_RESP);
        h_err    = (state_q == HS_RESP) && err_q;
        if (state_q == HS_EVAL) begin
            if (!is_aligned(cap_addr)) begin
                reject = 1'b1;
            end else begin
                unique case (word_of(cap_addr))
                    WORD_CTRL:  ctrl_we = 1'b1;
                    WORD_IDENT: begin
                        if (|((ident_i ^ cap_data) & ~REV_MASK) || !rev_allowed(rev_new))
                            reject = 1'b1;
                        else
                            rev_we = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dist_ctrl_regs.sv
module dist_ctrl_regs
    import dist_regs_pkg::*;
#(
    parameter int                NUM_IRQ     = 96,
    parameter int                MAX_CPU     = 8,
    parameter logic [3:0]        REV_RESET   = 4'd3,
    parameter logic [7:0]        PRODUCT_ID  = 8'h4B,
    parameter logic [11:0]       IMPLEMENTER = 12'h43B,
    localparam int               CPU_W       = $clog2(MAX_CPU + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_W-1:0]   online_cpus,
    input  logic               g_wr,
    input  logic               g_rd,
    input  logic [3:0]         g_addr,
    input  logic [31:0]        g_wdata,
    output logic [31:0]        g_rdata,
    output logic               g_rvalid,
    input  logic               h_wr,
    input  logic [3:0]         h_addr,
    input  logic [31:0]        h_wdata,
    output logic               h_done,
    output logic               h_err,
    output logic               fwd_enable,
    output logic               group_unlock,
    output logic [MAX_CPU-1:0] wake_o
);
    logic             en_q, en_d, rise;
    logic [REV_W-1:0] rev_q, rev_new;
    logic             unlock_q, rev_we, h_ctrl_we, h_ctrl_bit, g_ctrl_we;
    logic [31:0]      type_word, ident_word, rd_mux;
    logic             unused_wdata;

    assign unused_wdata = ^g_wdata[31:1];

    dist_type_word #(.NUM_IRQ(NUM_IRQ), .MAX_CPU(MAX_CPU)) u_type (
        .online_i(online_cpus), .word_o(type_word));

    dist_ident_word #(.PRODUCT_ID(PRODUCT_ID), .IMPLEMENTER(IMPLEMENTER)) u_ident (
        .rev_i(rev_q), .word_o(ident_word));

    dist_host_fsm u_host (
        .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
        .ident_i(ident_word), .h_done(h_done), .h_err(h_err),
        .rev_we(rev_we), .rev_new(rev_new), .ctrl_we(h_ctrl_we), .ctrl_bit(h_ctrl_bit));

    assign g_ctrl_we = g_wr && is_aligned(g_addr) && word_of(g_addr) == WORD_CTRL;

    always_comb begin
        en_d = en_q;
        if (g_ctrl_we)      en_d = g_wdata[0];
        else if (h_ctrl_we) en_d = h_ctrl_bit;
    end
    assign rise = en_d && !en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            rev_q    <= REV_RESET;
            unlock_q <= 1'b0;
        end else begin
            en_q <= en_d;
            if (rev_we) begin
                rev_q    <= rev_new;
                unlock_q <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < MAX_CPU; i++) begin : g_wake
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wake_o[i] <= 1'b0;
            else        wake_o[i] <= rise && (online_cpus > CPU_W'(i));
        end
    end

    always_comb begin
        rd_mux = '0;
        if (is_aligned(g_addr)) begin
            unique case (word_of(g_addr))
                WORD_CTRL:  rd_mux = {31'd0, en_q};
                WORD_TYPE:  rd_mux = type_word;
                WORD_IDENT: rd_mux = ident_word;
                WORD_RSVD:  rd_mux = '0;
                default:    rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_rvalid <= 1'b0;
            g_rdata  <= '0;
        end else begin
            g_rvalid <= g_rd;
            g_rdata  <= g_rd ? rd_mux : '0;
        end
    end

    assign fwd_enable   = en_q;
    assign group_unlock = unlock_q;
endmodule

// File: rtl/dist_regs_chk.sv
module dist_regs_chk #(
    parameter int MAX_CPU = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               g_rd,
    input logic               g_rvalid,
    input logic               h_done,
    input logic               h_err,
    input logic               fwd_enable,
    input logic               group_unlock,
    input logic [MAX_CPU-1:0] wake_o
);
    // R3
    wake_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_o) |-> (fwd_enable && !$past(fwd_enable)));

    // R3
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_o) |=> !(|wake_o));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_done |=> !h_done);

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_err |-> h_done);

    // R9
    unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        group_unlock |=> group_unlock);

    // R2
    rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        g_rvalid |-> $past(g_rd));
endmodule

bind dist_ctrl_regs dist_regs_chk #(.MAX_CPU(MAX_CPU)) u_chk (
    .clk(clk), .rst_n(rst_n), .g_rd(g_rd), .g_rvalid(g_rvalid),
    .h_done(h_done), .h_err(h_err), .fwd_enable(fwd_enable),
    .group_unlock(group_unlock), .wake_o(wake_o));

// File: tb/tb_dist_ctrl_regs.sv
module tb_dist_ctrl_regs;
    localparam int          NUM_IRQ = 256;
    localparam int          MAX_CPU = 8;
    localparam logic [3:0]  REV_RST = 4'd1;
    localparam logic [7:0]  PROD    = 8'h4B;
    localparam logic [11:0] IMPL    = 12'h43B;
    localparam int          CPU_W   = $clog2(MAX_CPU + 1);

    logic clk = 1'b0, rst_n;
    logic [CPU_W-1:0] online_cpus;
    logic g_wr, g_rd, h_wr;
    logic [3:0] g_addr, h_addr;
    logic [31:0] g_wdata, h_wdata, g_rdata;
    logic g_rvalid, h_done, h_err, fwd_enable, group_unlock;
    logic [MAX_CPU-1:0] wake_o;

    int total = 0, fails = 0;
    bit finished = 0;

    // model state
    bit m_en, m_unl;
    logic [3:0] m_rev;

    always #10 clk = ~clk;

    dist_ctrl_regs #(.NUM_IRQ(NUM_IRQ), .MAX_CPU(MAX_CPU), .REV_RESET(REV_RST),
                     .PRODUCT_ID(PROD), .IMPLEMENTER(IMPL)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ident_exp();
        return {PROD, 8'h00, m_rev, IMPL};
    endfunction

    function automatic logic [31:0] type_exp();
        logic [3:0] c = 4'(online_cpus) - 4'd1;
        return {24'd0, c[2:0], 5'(NUM_IRQ / 32 - 1)};
    endfunction

    function automatic logic [31:0] read_exp(input logic [3:0] a);
        if (a[1:0] != 2'b00) return 32'd0;
        case (a[3:2])
            2'd0:    return {31'd0, m_en};
            2'd1:    return type_exp();
            2'd2:    return ident_exp();
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [MAX_CPU-1:0] wake_mask(input bit w);
        return w ? MAX_CPU'((1 << online_cpus) - 1) : '0;
    endfunction

    task automatic check_state(input string tag);
        chk(fwd_enable == m_en, {tag, " R2 enable"}, 32'(fwd_enable), 32'(m_en));
        chk(group_unlock == m_unl, {tag, " R9 unlock"}, 32'(group_unlock), 32'(m_unl));
    endtask

    task automatic gwrite(input logic [3:0] a, input logic [31:0] d, input string tag);
        bit w = 0;
        @(negedge clk);
        g_wr = 1; g_addr = a; g_wdata = d;
        @(posedge clk);
        if (a[1:0] == 2'b00 && a[3:2] == 2'd0) begin
            w = !m_en && d[0];
            m_en = d[0];
        end
        @(negedge clk);
        g_wr = 0;
        chk(wake_o == wake_mask(w), {tag, " R3 wake"}, 32'(wake_o), 32'(wake_mask(w)));
        check_state(tag);
    endtask

    task automatic gread(input logic [3:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        g_rd = 1; g_addr = a;
        e = read_exp(a);
        @(negedge clk);
        g_rd = 0;
        chk(g_rvalid == 1'b1, {tag, " R2 rvalid"}, 32'(g_rvalid), 32'd1);
        chk(g_rdata == e, tag, g_rdata, e);
    endtask

    // hold_busy keeps h_wr high with altered data while the request is in progress
    task automatic hwrite(input logic [3:0] a, input logic [31:0] d, input bit hold_busy, input string tag);
        bit e = 0, w = 0;
        @(negedge clk);
        h_wr = 1; h_addr = a; h_wdata = d;
        @(negedge clk);
        if (hold_busy) h_wdata = ~d;
        else h_wr = 0;
        chk(h_done == 1'b0, "R11 early done", 32'(h_done), 32'd0);
        if (a[1:0] != 2'b00) e = 1;
        else if (a[3:2] == 2'd0) begin
            w = !m_en && d[0];
            m_en = d[0];
        end else if (a[3:2] == 2'd2) begin
            if (((ident_exp() ^ d) & ~32'h0000_F000) != 0) e = 1;
            else if (!(d[15:12] == 4'd2 || d[15:12] == 4'd3)) e = 1;
            else begin m_rev = d[15:12]; m_unl = 1; end
        end
        @(negedge clk);
        h_wr = 0;
        chk(h_done == 1'b1, "R11 done", 32'(h_done), 32'd1);
        chk(h_err == e, {tag, " err"}, 32'(h_err), 32'(e));
        chk(wake_o == wake_mask(w), {tag, " R12 wake"}, 32'(wake_o), 32'(wake_mask(w)));
        check_state(tag);
        @(negedge clk);
        chk(h_done == 1'b0, "R11 done one cycle", 32'(h_done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; g_wr = 0; g_rd = 0; h_wr = 0;
        g_addr = 0; h_addr = 0; g_wdata = 0; h_wdata = 0;
        online_cpus = CPU_W'(4);
        m_en = 0; m_unl = 0; m_rev = REV_RST;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(fwd_enable == 0, "R1 enable", 32'(fwd_enable), 0);
        chk(group_unlock == 0, "R1 unlock", 32'(group_unlock), 0);
        chk(wake_o == 0, "R1 wake", 32'(wake_o), 0);
        chk(h_done == 0, "R1 done", 32'(h_done), 0);
        gread(4'h8, "R1 reset revision");
        // R2 / R3 enable and wake
        gwrite(4'h0, 32'hFFFF_FFFF, "R3 rise");
        gread(4'h0, "R2 ctrl read");
        gwrite(4'h0, 32'h1, "R3 stay set");
        gwrite(4'h0, 32'hFFFF_FFFE, "R2 clear");
        online_cpus = CPU_W'(8);
        gwrite(4'h0, 32'h1, "R3 rise eight");
        gwrite(4'h0, 32'h0, "R2 clear again");
        // R4 type word over processor counts
        for (int c = 1; c <= MAX_CPU; c++) begin
            online_cpus = CPU_W'(c);
            gread(4'h4, "R4 type");
        end
        // R5 / R6 / R7
        gread(4'h8, "R5 ident");
        gwrite(4'h4, 32'hFFFF_FFFF, "R6 type write");
        gwrite(4'h8, 32'h0000_3000, "R6 ident write");
        gwrite(4'hC, 32'hFFFF_FFFF, "R6 rsvd write");
        gread(4'h8, "R6 ident unchanged");
        gread(4'hC, "R6 rsvd read");
        gwrite(4'h1, 32'h1, "R7 misaligned write");
        gread(4'h2, "R7 misaligned read");
        gread(4'h0, "R7 ctrl unchanged");
        // R10 repeating current word with revision 1 is rejected
        hwrite(4'h8, {PROD, 8'h00, 4'd1, IMPL}, 0, "R10 same word rev1");
        // R8 damage outside revision
        hwrite(4'h8, {PROD, 8'h01, 4'd3, IMPL}, 0, "R8 bad variant");
        hwrite(4'h8, {PROD ^ 8'h80, 8'h00, 4'd2, IMPL}, 0, "R8 bad product");
        // R9 accept
        hwrite(4'h8, {PROD, 8'h00, 4'd3, IMPL}, 0, "R9 rev3");
        gread(4'h8, "R9 rev read");
        hwrite(4'h8, {PROD, 8'h00, 4'd5, IMPL}, 0, "R10 rev5");
        hwrite(4'h8, {PROD, 8'h00, 4'd2, IMPL}, 0, "R9 rev2");
        gread(4'h8, "R9 rev2 read");
        // R12 host control
        hwrite(4'h0, 32'h1, 0, "R12 host ctrl set");
        hwrite(4'h0, 32'h0, 0, "R12 host ctrl clear");
        hwrite(4'h4, 32'hFFFF_FFFF, 0, "R12 host type");
        hwrite(4'h2, 32'h1, 0, "R12 host misaligned");
        // R11 busy port ignores further requests
        hwrite(4'h8, {PROD, 8'h00, 4'd3, IMPL}, 1, "R11 busy");
        @(negedge clk);
        chk(h_done == 0, "R11 no extra response", 32'(h_done), 0);
        // R12 guest priority over host on the same cycle
        @(negedge clk);
        h_wr = 1; h_addr = 4'h0; h_wdata = 32'h1;
        @(negedge clk);
        h_wr = 0; g_wr = 1; g_addr = 4'h0; g_wdata = 32'h0;
        @(negedge clk);
        g_wr = 0;
        chk(fwd_enable == 0, "R12 guest priority", 32'(fwd_enable), 0);
        chk(wake_o == 0, "R12 no wake on priority", 32'(wake_o), 0);
        @(negedge clk);
        // random traffic
        for (int k = 0; k < 400; k++) begin
            int op = $urandom_range(0, 5);
            logic [3:0] a = 4'($urandom);
            logic [31:0] d = $urandom;
            if ($urandom_range(0, 9) == 0) online_cpus = CPU_W'($urandom_range(1, MAX_CPU));
            if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
            case (op)
                0, 1: gwrite(a, d, "R2 rand guest write");
                2, 3: gread(a, "R6 rand guest read");
                default: begin
                    if ($urandom_range(0, 1) == 1) begin
                        a = 4'h8;
                        d = ident_exp();
                        d[15:12] = 4'($urandom);
                        if ($urandom_range(0, 2) == 0) d[$urandom_range(16, 31)] ^= 1'b1;
                    end
                    hwrite(a, d, 0, "R9 rand host write");
                end
            endcase
        end
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule